// File: doc/BRIEF.md
# Two-Channel Wiper Register Slave on an I2C Bus

This block is an I2C-compatible bus slave that stores the tap settings of two 8-bit resistor-ladder channels. A bus master addresses it with a 7-bit address. The upper five bits of that address are fixed and the lower two come from strap pins, so four of these slaves can sit on one bus. On a write, the master first sends a command byte. One bit of the command selects a channel, one bit snaps that channel to the centre tap, and one bit sets or clears that channel's shutdown. Any bytes that follow are loaded into the selected channel. On a read, the slave returns the code of the channel that the last command selected. It repeats that code for as long as the master acknowledges.

SCL and SDA are sampled by the system clock through a synchroniser, which also detects bus edges and START and STOP conditions. The protocol state machine has these states: IDLE (wait for START), ADDR (shift in the address byte), ADDR_ACK, INSTR (shift in the command byte), INSTR_ACK, DATA (shift in a code byte), DATA_ACK, READ (shift out a code byte), READ_ACK (sample the master's acknowledge) and WAIT (ignore the bus until the next START or STOP). The transitions are as follows:
- START from any state goes to ADDR, and STOP from any state goes to IDLE.
- At the end of a received byte, ADDR goes to ADDR_ACK on an address match and to WAIT otherwise, INSTR goes to INSTR_ACK, and DATA goes to DATA_ACK.
- At the end of the acknowledge pulse, ADDR_ACK goes to READ or INSTR depending on the direction bit, and INSTR_ACK and DATA_ACK both go to DATA.
- READ goes to READ_ACK after eight bits. READ_ACK goes back to READ on a master acknowledge and to WAIT on a master no-acknowledge.

Top module: `dpot_i2c_slave`

## Requirements
- R1: While the synchronous reset is high and after it is released, both channel codes are 128 (0x80), both stored shutdown flags are clear, and SDA is not driven.
- R2: The slave acknowledges (drives SDA low during the ninth SCL pulse) an address byte whose upper seven bits equal {5'b01011, strap_i[1], strap_i[0]}. For any other address it acknowledges nothing and changes no code or flag until the next START.
- R3: Bit 7 of the command byte selects the channel. 0 selects channel 0, which is wiper_o[7:0] and shut_o[0]. 1 selects channel 1, which is wiper_o[15:8] and shut_o[1].
- R4: When bit 6 of the command byte is 1, the selected channel's code becomes 128. Data bytes later in the same write then leave the code unchanged.
- R5: Bit 5 of the command byte is written into the selected channel's shutdown flag: 1 sets it and 0 clears it. The other channel's flag and both codes are unaffected.
- R6: In a write (direction bit 0), every byte after the command byte loads the selected channel's code, so the last one wins. The command byte and every data byte are acknowledged.
- R7: In a read (direction bit 1), the slave sends the selected channel's code MSB first. It sends the code again after each master acknowledge, and it releases SDA after a master no-acknowledge.
- R8: While shdn_n_i is low, both shut_o bits read 1. The stored flags are kept and reappear when the pin returns high.
- R9: A START at any point, including in the middle of a transfer, restarts address decoding. A STOP returns the slave to idle with SDA released, and bits clocked while idle are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| strap_i | input | 2 | Address strap levels, low two address bits |
| shdn_n_i | input | 1 | Active-low shutdown pin, forces both channels |
| wiper_o | output | 16 | Channel codes, channel 1 in [15:8], channel 0 in [7:0] |
| shut_o | output | 2 | Per-channel shutdown, bit n for channel n |

## Verification
The write path is driven with command bytes for each channel. The data bytes include single loads, back-to-back loads and loads that come after a midscale command. These show whether the select bit steers both the code and the flag to the correct channel, and whether a midscale command blocks later data. Address bytes that differ only in a strap bit, and ones that differ in the fixed prefix, show whether the decode covers both parts of the address. Reads that come straight after a write, and reads after a repeated START, show whether the returned code follows the most recent command. Reads of two bytes that end in a no-acknowledge show both the repeat behaviour and the release of SDA.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    localparam int BYTE_W = 8;
    localparam int NCH    = 2;
    localparam int ADDR_W = 7;
    localparam logic [BYTE_W-1:0] CODE_MID = 8'h80;

    // command byte field positions
    localparam int SEL_BIT = 7;
    localparam int MID_BIT = 6;
    localparam int SD_BIT  = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_READ,
        ST_READ_ACK,
        ST_WAIT
    } dpot_st_e;

endpackage

// File: rtl/dpot_bus_sync.sv
module dpot_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    // data edges while the clock stays high frame a transfer
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/dpot_i2c_fsm.sv
module dpot_i2c_fsm
    import dpot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [BYTE_W-1:0] rd_code,
    output logic              sda_oe,
    output dpot_st_e          state_o,
    output logic              instr_we,
    output logic              data_we,
    output logic [BYTE_W-1:0] rx_byte
);

    localparam int CNT_W = $clog2(BYTE_W + 1);

    dpot_st_e          state_q, state_d;
    logic [BYTE_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              rw_q;
    logic              nack_q;
    logic              oe_q;
    logic              instr_we_q;
    logic              data_we_q;

    logic byte_full;
    logic last_out;
    logic addr_hit;

    assign byte_full = (cnt_q == CNT_W'(BYTE_W));
    assign last_out  = (cnt_q == CNT_W'(BYTE_W - 1));
    assign addr_hit  = (shreg_q[BYTE_W-1:1] == dev_addr);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else if (scl_fall) begin
            unique case (state_q)
                ST_ADDR:      if (byte_full) state_d = addr_hit ? ST_ADDR_ACK : ST_WAIT;
                ST_INSTR:     if (byte_full) state_d = ST_INSTR_ACK;
                ST_DATA:      if (byte_full) state_d = ST_DATA_ACK;
                ST_ADDR_ACK:  state_d = rw_q ? ST_READ : ST_INSTR;
                ST_INSTR_ACK: state_d = ST_DATA;
                ST_DATA_ACK:  state_d = ST_DATA;
                ST_READ:      if (last_out) state_d = ST_READ_ACK;
                ST_READ_ACK:  state_d = nack_q ? ST_WAIT : ST_READ;
                default:      state_d = state_q;
            endcase
        end
    end

    // shifter, counter, line drive and strobes
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q    <= '0;
            cnt_q      <= '0;
            rw_q       <= 1'b0;
            nack_q     <= 1'b0;
            oe_q       <= 1'b0;
            instr_we_q <= 1'b0;
            data_we_q  <= 1'b0;
        end else begin
            instr_we_q <= 1'b0;
            data_we_q  <= 1'b0;
            if (stop_det || start_det) begin
                oe_q  <= 1'b0;
                cnt_q <= '0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_INSTR, ST_DATA: begin
                        if (scl_rise && !byte_full) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
                            cnt_q   <= cnt_q + CNT_W'(1);
                        end else if (scl_fall && byte_full) begin
                            cnt_q <= '0;
                            if (state_q == ST_ADDR) begin
                                rw_q <= shreg_q[0];
                                oe_q <= addr_hit;
                            end else begin
                                oe_q       <= 1'b1;
                                instr_we_q <= (state_q == ST_INSTR);
                                data_we_q  <= (state_q == ST_DATA);
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_INSTR_ACK, ST_DATA_ACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if (state_q == ST_ADDR_ACK && rw_q) begin
                                shreg_q <= rd_code;
                                oe_q    <= ~rd_code[BYTE_W-1];
                            end else begin
                                oe_q <= 1'b0;
                            end
                        end
                    end
                    ST_READ: begin
                        if (scl_fall) begin
                            if (last_out) begin
                                oe_q  <= 1'b0;
                                cnt_q <= '0;
                            end else begin
                                shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                                oe_q    <= ~shreg_q[BYTE_W-2];
                                cnt_q   <= cnt_q + CNT_W'(1);
                            end
                        end
                    end
                    ST_READ_ACK: begin
                        if (scl_rise) begin
                            nack_q <= sda_s;
                        end else if (scl_fall && !nack_q) begin
                            shreg_q <= rd_code;
                            oe_q    <= ~rd_code[BYTE_W-1];
                            cnt_q   <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe   = oe_q;
    assign state_o  = state_q;
    assign instr_we = instr_we_q;
    assign data_we  = data_we_q;
    assign rx_byte  = shreg_q;

endmodule

// File: rtl/dpot_wiper_regs.sv
module dpot_wiper_regs
    import dpot_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  instr_we,
    input  logic                  data_we,
    input  logic [BYTE_W-1:0]     rx_byte,
    output logic [NCH*BYTE_W-1:0] codes_o,
    output logic [NCH-1:0]        shut_o,
    output logic [BYTE_W-1:0]     rd_code
);

    logic sel_q;
    logic mid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
            mid_q <= 1'b0;
        end else if (instr_we) begin
            sel_q <= rx_byte[SEL_BIT];
            mid_q <= rx_byte[MID_BIT];
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam logic CH_BIT = (ch != 0);
        logic [BYTE_W-1:0] code_r;
        logic              shut_r;
        logic              cmd_hit;
        logic              load_hit;

        assign cmd_hit  = instr_we && (rx_byte[SEL_BIT] == CH_BIT);
        assign load_hit = data_we && (sel_q == CH_BIT) && !mid_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                code_r <= CODE_MID;
                shut_r <= 1'b0;
            end else if (cmd_hit) begin
                shut_r <= rx_byte[SD_BIT];
                if (rx_byte[MID_BIT]) code_r <= CODE_MID;
            end else if (load_hit) begin
                code_r <= rx_byte;
            end
        end

        assign codes_o[ch*BYTE_W +: BYTE_W] = code_r;
        assign shut_o[ch]                   = shut_r;
    end

    assign rd_code = sel_q ? codes_o[BYTE_W +: BYTE_W] : codes_o[0 +: BYTE_W];

endmodule

// File: rtl/dpot_i2c_slave.sv
module dpot_i2c_slave
    import dpot_pkg::*;
#(
    parameter logic [4:0] ADDR_HI     = 5'b01011,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    input  logic [1:0]            strap_i,
    input  logic                  shdn_n_i,
    output logic [NCH*BYTE_W-1:0] wiper_o,
    output logic [NCH-1:0]        shut_o
);

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [ADDR_W-1:0] dev_addr;
    logic [BYTE_W-1:0] rd_code;
    logic [BYTE_W-1:0] rx_byte;
    logic              instr_we, data_we;
    logic [NCH-1:0]    shut_flags;
    dpot_st_e          fsm_state;

    assign dev_addr = {ADDR_HI, strap_i};

    dpot_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    dpot_i2c_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (sda_s),
        .dev_addr  (dev_addr),
        .rd_code   (rd_code),
        .sda_oe    (sda_oe),
        .state_o   (fsm_state),
        .instr_we  (instr_we),
        .data_we   (data_we),
        .rx_byte   (rx_byte)
    );

    dpot_wiper_regs regs_i (
        .clk      (clk),
        .rst      (rst),
        .instr_we (instr_we),
        .data_we  (data_we),
        .rx_byte  (rx_byte),
        .codes_o  (wiper_o),
        .shut_o   (shut_flags),
        .rd_code  (rd_code)
    );

    // the pin overrides every stored flag without touching it
    assign shut_o = shut_flags | {NCH{~shdn_n_i}};

endmodule

// File: rtl/dpot_i2c_checker.sv
module dpot_i2c_checker
    import dpot_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  scl_s,
    input logic                  stop_det,
    input logic                  sda_oe,
    input dpot_st_e              fsm_state,
    input logic [NCH*BYTE_W-1:0] wiper_o
);

    // R1: codes sit at midscale and the line is free when reset ends
    a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (wiper_o == {NCH{CODE_MID}}) && !sda_oe);

    // R2: no line drive while idle or ignoring the bus
    a_r2_quiet_when_unselected: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == ST_IDLE || fsm_state == ST_WAIT) |-> !sda_oe);

    // R7: the slave starts pulling the line only while the clock is low
    a_r7_drive_on_low_clock: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);

    // R9: a stop condition leads to idle with the line released
    a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (fsm_state == ST_IDLE) && !sda_oe);

    // R6: codes only move inside a write transfer
    a_r6_codes_hold_in_idle: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == ST_IDLE) |=> $stable(wiper_o));

endmodule

bind dpot_i2c_slave dpot_i2c_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .fsm_state (fsm_state),
    .wiper_o   (wiper_o)
);

// File: tb/dpot_i2c_slave_tb_top.sv
module dpot_i2c_slave_tb_top;

    localparam int Q = 20;  // quarter bit time in clocks

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        shdn_n = 1'b1;
    logic [1:0]  strap = 2'b10;      // address 0101110: write 0x5C, read 0x5D
    logic        sda_oe;
    logic        sda_line;
    logic [15:0] wiper;
    logic [1:0]  shut;

    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic [7:0]  exp_q[$];
    logic [7:0]  rd_last;
    logic [7:0]  mon_exp;
    logic        ack;
    event        rd_ev;

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    dpot_i2c_slave dut_i (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .strap_i  (strap),
        .shdn_n_i (shdn_n),
        .wiper_o  (wiper),
        .shut_o   (shut)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic a);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        a = ~sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    // driver side of the scoreboard: push the expected byte, then clock it out
    task automatic rd_byte(input logic mack, input logic [7:0] expv);
        logic [7:0] v;
        exp_q.push_back(expv);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_m = 1'b1;
            tick(Q); v[i] = sda_line;
            tick(Q); scl_m = 1'b0;
            tick(Q);
        end
        put_bit(~mack);
        sda_m = 1'b1;
        rd_last = v;
        -> rd_ev;
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            @(rd_ev);
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R7 read byte act=%0h exp=none", rd_last);
            end else begin
                mon_exp = exp_q.pop_front();
                if (rd_last !== mon_exp) begin
                    errors++;
                    $display("FAIL R7 read byte act=%0h exp=%0h", rd_last, mon_exp);
                end
            end
        end
    end

    task automatic write_cmd(input logic [7:0] cmd, input int ndata,
                             input logic [7:0] d0, input logic [7:0] d1);
        bus_start();
        wr_byte(8'h5C, ack); chk("R2 address ack", ack, 1);
        wr_byte(cmd, ack);   chk("R6 command ack", ack, 1);
        if (ndata > 0) begin wr_byte(d0, ack); chk("R6 data ack", ack, 1); end
        if (ndata > 1) begin wr_byte(d1, ack); chk("R6 data ack", ack, 1); end
        bus_stop();
        tick(4);
    endtask

    initial begin
        tick(5);
        chk("R1 reset codes", wiper, 16'h8080);
        chk("R1 reset shut", shut, 2'b00);
        chk("R1 reset line", sda_oe, 0);
        rst = 1'b0;
        tick(10);

        // R3 / R6: channel 0 load
        write_cmd(8'h00, 1, 8'h3C, 8'h00);
        chk("R3 ch0 loaded", wiper, 16'h803C);

        // R6: two data bytes to channel 1, last wins
        write_cmd(8'h80, 2, 8'hA5, 8'h5A);
        chk("R6 ch1 last byte wins", wiper, 16'h5A3C);

        // R2: strap mismatch, nothing acked or changed
        bus_start();
        wr_byte(8'h5E, ack); chk("R2 strap mismatch nack", ack, 0);
        wr_byte(8'h00, ack); chk("R2 ignored byte nack", ack, 0);
        wr_byte(8'h11, ack); chk("R2 ignored byte nack", ack, 0);
        bus_stop(); tick(4);
        chk("R2 codes unchanged", wiper, 16'h5A3C);
        bus_start();
        wr_byte(8'h1C, ack); chk("R2 prefix mismatch nack", ack, 0);
        bus_stop(); tick(4);

        // R7: read returns channel 1, repeats on ack, releases after nack
        bus_start();
        wr_byte(8'h5D, ack); chk("R2 read address ack", ack, 1);
        rd_byte(1'b1, 8'h5A);
        rd_byte(1'b0, 8'h5A);
        tick(4);
        chk("R7 line released after nack", sda_oe, 0);
        bus_stop(); tick(4);

        // R4: midscale on channel 0 blocks the following data byte
        write_cmd(8'h40, 1, 8'h11, 8'h00);
        chk("R4 midscale ignores data", wiper, 16'h5A80);

        // R5: shutdown flags per channel
        write_cmd(8'hA0, 0, 8'h00, 8'h00);
        chk("R5 ch1 shutdown set", shut, 2'b10);
        write_cmd(8'h20, 0, 8'h00, 8'h00);
        chk("R5 ch0 shutdown set", shut, 2'b11);
        write_cmd(8'h80, 0, 8'h00, 8'h00);
        chk("R5 ch1 shutdown cleared", shut, 2'b01);
        chk("R5 codes untouched", wiper, 16'h5A80);

        // R8: pin forces both, stored flags return
        shdn_n = 1'b0; tick(2);
        chk("R8 pin forces shutdown", shut, 2'b11);
        shdn_n = 1'b1; tick(2);
        chk("R8 stored flags return", shut, 2'b01);

        // R9: repeated start turns a write into a read of channel 0
        bus_start();
        wr_byte(8'h5C, ack); chk("R2 address ack", ack, 1);
        wr_byte(8'h00, ack); chk("R6 command ack", ack, 1);
        bus_start();
        wr_byte(8'h5D, ack); chk("R9 repeated start address ack", ack, 1);
        rd_byte(1'b0, 8'h80);
        bus_stop(); tick(4);
        chk("R5 ch0 shutdown cleared", shut, 2'b00);

        // R3 / R7: load and read back channel 0
        write_cmd(8'h00, 1, 8'h77, 8'h00);
        bus_start();
        wr_byte(8'h5D, ack); chk("R2 read address ack", ack, 1);
        rd_byte(1'b0, 8'h77);
        bus_stop(); tick(4);
        chk("R3 final codes", wiper, 16'h5A77);

        // R9: bits clocked while idle are ignored
        chk("R9 line free after stop", sda_oe, 0);
        wr_byte(8'h5C, ack); chk("R9 idle byte not acked", ack, 0);
        wr_byte(8'h55, ack); chk("R9 idle byte not acked", ack, 0);
        bus_stop(); tick(4);
        chk("R9 codes after idle bits", wiper, 16'h5A77);

        // R1: a second reset restores midscale
        rst = 1'b1; tick(3);
        rst = 1'b0; tick(3);
        chk("R1 re-reset codes", wiper, 16'h8080);
        chk("R1 re-reset shut", shut, 2'b00);

        tick(10);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule